// File: doc/BRIEF.md
# Debug-Port Command Completion Checker

This block watches the status side of a processor debug control port after a command has been issued to it. When a request starts, the block records the wait mode, the expected read data, a don't-care mask and the expected error flags. It then waits for the completion condition of that mode. In command mode the condition is the port's acknowledge. In step mode it is busy low together with the step-in-progress flag low. In run-wait mode it is busy low together with the CPU-running flag low.

Each mode has its own cycle limit, set by a parameter. When the limit runs out first, the block reports a timeout. It then drives a reset request for one cycle and refuses new requests for a fixed gap of cycles. When the command completes in time, the block classifies the outcome. An error flag is checked first, then the memory-error flag, then the masked data compare. Each error is reported as unexpected, expected and seen, or expected but missed. A 3-bit result code and the elapsed cycle count are reported together with a one-cycle done pulse.

Top module: `cmd_watch`

## Requirements
- R1: While `rst` is high and after its release, `done`, `result`, `cycles`, `timeout` and `reset_req` are all zero until the first completion.
- R2: The request is accepted on the clock edge where `start` is high, counting as cycle 1. Completion in command mode (`mode`=0, and the reserved value 3, which acts the same) depends only on `st_ack` being high. `st_busy` has no effect in this mode.
- R3: In step mode (`mode`=1), completion needs `st_busy` low and `st_step` low in the same sample. Either one alone does not complete the command.
- R4: In run-wait mode (`mode`=2), completion needs `st_busy` low and `st_run` low in the same sample. Either one alone does not complete the command.
- R5: All status inputs are registered every clock, and completion is judged on the registered copy. A status level that is present only on the request edge never completes a command. A condition that first reaches the ports before edge j after the request completes at edge j+1 with `cycles` = j+1, so the smallest count reported is 2.
- R6: The timeout limits are `TMO_CMD`, `TMO_STEP` and `TMO_GO`. If the command has not completed by the edge where the count equals the mode's limit, `done` pulses with `result`=6, `timeout`=1 and `cycles` equal to the limit. A completion at that same edge is reported as a normal completion instead.
- R7: On a timeout, `reset_req` is high for exactly one cycle, in the same cycle as `done`. `start` is then ignored on the next `RST_GAP` edges and is accepted again on the edge after them.
- R8: The data compare fails (`result`=1) only when the data check was requested and `(st_dout ^ exp_data) & ~exp_mask` is non-zero. A mask bit of 1 makes that bit don't-care. When no check is requested, or the compare passes and no error applies, `result`=0.
- R9: Error classification comes before the memory-error classification, which comes before the data compare. The error codes are 2 for unexpected, 3 for expected but missed, and 7 for expected and seen. The memory-error codes are 4 for unexpected, 5 for expected but missed, and 7 for expected and seen.
- R10: `mode`, `exp_data`, `exp_mask`, `chk_data`, `exp_err` and `exp_merr` are captured on the request edge. Changing them while the command is in flight has no effect on its result or timing.
- R11: `done` is a one-cycle pulse. `result`, `cycles` and `timeout` keep their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request start strobe |
| mode | input | 2 | Wait mode: 0 command, 1 step, 2 run-wait, 3 same as 0 |
| exp_data | input | DATA_W | Expected read data |
| exp_mask | input | DATA_W | Don't-care mask, 1 = ignore bit |
| chk_data | input | 1 | Request a data compare |
| exp_err | input | 1 | Error flag is expected |
| exp_merr | input | 1 | Memory-error flag is expected |
| st_busy | input | 1 | Port busy |
| st_ack | input | 1 | Port acknowledge |
| st_err | input | 1 | Port command error |
| st_merr | input | 1 | Port memory error |
| st_run | input | 1 | CPU running |
| st_step | input | 1 | Single step in progress |
| st_dout | input | DATA_W | Port read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code |
| cycles | output | CNT_W | Cycle count of the last command |
| timeout | output | 1 | Last command timed out |
| reset_req | output | 1 | One-cycle reset request after a timeout |

## Verification
The bench builds the block with limits of 6, 8 and 12 cycles for command, step and run-wait modes, an 8-bit counter and the default gap of 9. With these values, every timeout path, including completion on exactly the limit cycle and one cycle past it, is reached within a few cycles. The short run-wait limit also lets the bench show that the CPU-running flag alone never completes a command. The default gap keeps the reset spacing at its real length, so the bench can place one ignored request on the last blocked edge and an accepted request on the very next one.

// File: rtl/cw_pkg.sv
package cw_pkg;

  typedef enum logic [1:0] {
    MODE_CMD  = 2'd0,
    MODE_STEP = 2'd1,
    MODE_GO   = 2'd2,
    MODE_RSV  = 2'd3
  } wait_mode_e;

  typedef enum logic [2:0] {
    RES_OK         = 3'd0,
    RES_DATA_FAIL  = 3'd1,
    RES_ERR_UNEXP  = 3'd2,
    RES_ERR_MISS   = 3'd3,
    RES_MERR_UNEXP = 3'd4,
    RES_MERR_MISS  = 3'd5,
    RES_TIMEOUT    = 3'd6,
    RES_ERR_SEEN   = 3'd7
  } result_e;

  typedef struct packed {
    logic busy;
    logic ack;
    logic err;
    logic merr;
    logic run;
    logic step;
  } port_stat_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_HOLD = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cw_stat_sample.sv
module cw_stat_sample
  import cw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  port_stat_t        stat_in,
  input  logic [DATA_W-1:0] dout_in,
  output port_stat_t        stat_q,
  output logic [DATA_W-1:0] dout_q
);

  // status is captured every cycle, independent of the sequencer state
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      dout_q <= '0;
    end else begin
      stat_q <= stat_in;
      dout_q <= dout_in;
    end
  end

endmodule

// File: rtl/cw_arrive.sv
module cw_arrive
  import cw_pkg::*;
(
  input  wait_mode_e mode,
  input  logic       busy,
  input  logic       ack,
  input  logic       run,
  input  logic       step,
  output logic       met
);

  always_comb begin
    unique case (mode)
      MODE_STEP: met = !busy && !step;
      MODE_GO:   met = !busy && !run;
      default:   met = ack;
    endcase
  end

endmodule

// File: rtl/cw_verdict.sv
module cw_verdict
  import cw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              err_seen,
  input  logic              merr_seen,
  input  logic [DATA_W-1:0] dout,
  input  logic              want_err,
  input  logic              want_merr,
  input  logic              want_cmp,
  input  logic [DATA_W-1:0] ref_data,
  input  logic [DATA_W-1:0] dc_mask,
  output result_e           code
);

  logic [DATA_W-1:0] diff_bits;
  logic              data_bad;

  assign diff_bits = (dout ^ ref_data) & ~dc_mask;
  assign data_bad  = want_cmp && (diff_bits != '0);

  // error flag first, memory error second, data compare last
  always_comb begin
    if (err_seen || want_err) begin
      if (err_seen && want_err)  code = RES_ERR_SEEN;
      else if (err_seen)         code = RES_ERR_UNEXP;
      else                       code = RES_ERR_MISS;
    end else if (merr_seen || want_merr) begin
      if (merr_seen && want_merr) code = RES_ERR_SEEN;
      else if (merr_seen)         code = RES_MERR_UNEXP;
      else                        code = RES_MERR_MISS;
    end else if (data_bad) begin
      code = RES_DATA_FAIL;
    end else begin
      code = RES_OK;
    end
  end

endmodule

// File: rtl/cw_seq.sv
module cw_seq
  import cw_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TMO_CMD  = 50,
  parameter int TMO_STEP = 100,
  parameter int TMO_GO   = 5000,
  parameter int RST_GAP  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             met,
  input  result_e          verdict,
  output logic             take,
  output wait_mode_e       cur_mode,
  output logic             done,
  output logic [2:0]       result,
  output logic [CNT_W-1:0] cycles,
  output logic             timeout,
  output logic             reset_req
);

  localparam logic [CNT_W-1:0] LIM_CMD  = CNT_W'(TMO_CMD);
  localparam logic [CNT_W-1:0] LIM_STEP = CNT_W'(TMO_STEP);
  localparam logic [CNT_W-1:0] LIM_GO   = CNT_W'(TMO_GO);
  localparam int               HOLD_W   = $clog2(RST_GAP + 2);
  localparam logic [HOLD_W-1:0] HOLD_LD = HOLD_W'(RST_GAP);

  seq_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [HOLD_W-1:0]  hold;
  logic [CNT_W-1:0]   lim;
  logic               settled;

  assign take    = (state == SEQ_IDLE) && start;
  // the first evaluation sees status from the request edge itself
  assign settled = (cnt >= CNT_W'(2)) && met;

  always_comb begin
    unique case (cur_mode)
      MODE_STEP: lim = LIM_STEP;
      MODE_GO:   lim = LIM_GO;
      default:   lim = LIM_CMD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      cnt       <= '0;
      hold      <= '0;
      cur_mode  <= MODE_CMD;
      done      <= 1'b0;
      result    <= '0;
      cycles    <= '0;
      timeout   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      done      <= 1'b0;
      reset_req <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            cur_mode <= wait_mode_e'(mode);
            cnt      <= CNT_W'(1);
            state    <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (settled) begin
            done    <= 1'b1;
            result  <= verdict;
            cycles  <= cnt;
            timeout <= 1'b0;
            state   <= SEQ_IDLE;
          end else if (cnt >= lim) begin
            done      <= 1'b1;
            result    <= RES_TIMEOUT;
            cycles    <= cnt;
            timeout   <= 1'b1;
            reset_req <= 1'b1;
            hold      <= HOLD_LD;
            state     <= SEQ_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_HOLD: begin
          if (hold <= HOLD_W'(1)) state <= SEQ_IDLE;
          else                    hold  <= hold - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_watch.sv
module cmd_watch
  import cw_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int TMO_CMD  = 50,
  parameter int TMO_STEP = 100,
  parameter int TMO_GO   = 5000,
  parameter int RST_GAP  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [DATA_W-1:0] exp_mask,
  input  logic              chk_data,
  input  logic              exp_err,
  input  logic              exp_merr,
  input  logic              st_busy,
  input  logic              st_ack,
  input  logic              st_err,
  input  logic              st_merr,
  input  logic              st_run,
  input  logic              st_step,
  input  logic [DATA_W-1:0] st_dout,
  output logic              done,
  output logic [2:0]        result,
  output logic [CNT_W-1:0]  cycles,
  output logic              timeout,
  output logic              reset_req
);

  port_stat_t        stat_now;
  port_stat_t        stat_q;
  logic [DATA_W-1:0] dout_q;
  logic              take;
  wait_mode_e        cur_mode;
  logic              met;
  result_e           verdict;

  logic [DATA_W-1:0] ref_q;
  logic [DATA_W-1:0] mask_q;
  logic              cmp_q;
  logic              werr_q;
  logic              wmerr_q;

  assign stat_now = '{busy: st_busy, ack: st_ack, err: st_err,
                      merr: st_merr, run: st_run, step: st_step};

  cw_stat_sample #(.DATA_W(DATA_W)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .stat_in (stat_now),
    .dout_in (st_dout),
    .stat_q  (stat_q),
    .dout_q  (dout_q)
  );

  // expectations are frozen at the accepted request
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      mask_q  <= '0;
      cmp_q   <= 1'b0;
      werr_q  <= 1'b0;
      wmerr_q <= 1'b0;
    end else if (take) begin
      ref_q   <= exp_data;
      mask_q  <= exp_mask;
      cmp_q   <= chk_data;
      werr_q  <= exp_err;
      wmerr_q <= exp_merr;
    end
  end

  cw_arrive u_arr (
    .mode (cur_mode),
    .busy (stat_q.busy),
    .ack  (stat_q.ack),
    .run  (stat_q.run),
    .step (stat_q.step),
    .met  (met)
  );

  cw_verdict #(.DATA_W(DATA_W)) u_vrd (
    .err_seen  (stat_q.err),
    .merr_seen (stat_q.merr),
    .dout      (dout_q),
    .want_err  (werr_q),
    .want_merr (wmerr_q),
    .want_cmp  (cmp_q),
    .ref_data  (ref_q),
    .dc_mask   (mask_q),
    .code      (verdict)
  );

  cw_seq #(
    .CNT_W    (CNT_W),
    .TMO_CMD  (TMO_CMD),
    .TMO_STEP (TMO_STEP),
    .TMO_GO   (TMO_GO),
    .RST_GAP  (RST_GAP)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode      (mode),
    .met       (met),
    .verdict   (verdict),
    .take      (take),
    .cur_mode  (cur_mode),
    .done      (done),
    .result    (result),
    .cycles    (cycles),
    .timeout   (timeout),
    .reset_req (reset_req)
  );

endmodule

// File: rtl/cmd_watch_chk.sv
module cmd_watch_chk #(
  parameter int CNT_W   = 16,
  parameter int RST_GAP = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic [2:0]       result,
  input logic [CNT_W-1:0] cycles,
  input logic             timeout,
  input logic             reset_req
);

  int unsigned gap_cnt;

  always_ff @(posedge clk) begin
    if (rst)             gap_cnt <= 0;
    else if (reset_req)  gap_cnt <= RST_GAP + 1;
    else if (gap_cnt != 0) gap_cnt <= gap_cnt - 1;
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_outputs_held_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(cycles) && $stable(timeout)));

  assert_tmo_code_R6: assert property (@(posedge clk) disable iff (rst)
    (done && timeout) |-> (result == 3'd6));

  assert_tmo_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (done && result == 3'd6) |-> timeout);

  assert_rst_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  assert_rst_with_tmo_R7: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (done && timeout));

  assert_no_done_in_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (gap_cnt != 0) |-> !done);

  assert_min_count_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !timeout) |-> (cycles >= CNT_W'(2)));

endmodule

bind cmd_watch cmd_watch_chk #(.CNT_W(CNT_W), .RST_GAP(RST_GAP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .result    (result),
  .cycles    (cycles),
  .timeout   (timeout),
  .reset_req (reset_req)
);

// File: tb/sim_cmd_watch.sv
module sim_cmd_watch;

  localparam int CLK_PER = 10;
  localparam int DW      = 16;
  localparam int CW      = 8;
  localparam int L_CMD   = 6;
  localparam int L_STEP  = 8;
  localparam int L_GO    = 12;
  localparam int GAP     = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [DW-1:0] exp_data = '0;
  logic [DW-1:0] exp_mask = '0;
  logic          chk_data = 1'b0;
  logic          exp_err = 1'b0;
  logic          exp_merr = 1'b0;
  logic          st_busy = 1'b1;
  logic          st_ack = 1'b0;
  logic          st_err = 1'b0;
  logic          st_merr = 1'b0;
  logic          st_run = 1'b1;
  logic          st_step = 1'b1;
  logic [DW-1:0] st_dout = '0;
  logic          done;
  logic [2:0]    result;
  logic [CW-1:0] cycles;
  logic          timeout;
  logic          reset_req;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit skip_settle = 1'b0;

  logic [2:0] q_res[$];
  int         q_cyc[$];
  bit         q_tmo[$];
  string      q_tag[$];

  always #(CLK_PER/2) clk = ~clk;

  cmd_watch #(
    .DATA_W(DW), .CNT_W(CW), .TMO_CMD(L_CMD), .TMO_STEP(L_STEP),
    .TMO_GO(L_GO), .RST_GAP(GAP)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .exp_data(exp_data), .exp_mask(exp_mask), .chk_data(chk_data),
    .exp_err(exp_err), .exp_merr(exp_merr),
    .st_busy(st_busy), .st_ack(st_ack), .st_err(st_err), .st_merr(st_merr),
    .st_run(st_run), .st_step(st_step), .st_dout(st_dout),
    .done(done), .result(result), .cycles(cycles), .timeout(timeout),
    .reset_req(reset_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [2:0] classify(
      input bit ferr, input bit fmerr, input bit ee, input bit emm,
      input bit ck, input logic [DW-1:0] dout, input logic [DW-1:0] ed,
      input logic [DW-1:0] em);
    if (ferr || ee)   return (ferr && ee) ? 3'd7 : (ferr ? 3'd2 : 3'd3);
    if (fmerr || emm) return (fmerr && emm) ? 3'd7 : (fmerr ? 3'd4 : 3'd5);
    if (ck && (((dout ^ ed) & ~em) != '0)) return 3'd1;
    return 3'd0;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_res.size() == 0) begin
        check(1'b0, "R11 unexpected done", 1, 0);
      end else begin
        logic [2:0] er;
        int ec;
        bit et;
        string tg;
        er = q_res.pop_front();
        ec = q_cyc.pop_front();
        et = q_tmo.pop_front();
        tg = q_tag.pop_front();
        check(result == er, {tg, " result"}, int'(result), int'(er));
        check(int'(cycles) == ec, {tg, " cycles"}, int'(cycles), ec);
        check(timeout == et, {tg, " timeout"}, int'(timeout), int'(et));
      end
    end
  end

  // must be called at a negedge; jb/jf = 0 means never
  task automatic run_cmd(input logic [1:0] m, input int jb, input int jf,
      input bit pre, input logic [DW-1:0] ed, input logic [DW-1:0] em,
      input bit ck, input bit ee, input bit emm, input bit ferr,
      input bit fmerr, input logic [DW-1:0] fdout, input string tag);
    int lim;
    int c;
    bit never;
    lim = (m == 2'd1) ? L_STEP : ((m == 2'd2) ? L_GO : L_CMD);
    never = (jf == 0) || ((m == 2'd1 || m == 2'd2) && jb == 0);
    c = (m == 2'd1 || m == 2'd2) ? (((jb > jf) ? jb : jf) + 1) : (jf + 1);
    if (never || c > lim) begin
      q_res.push_back(3'd6); q_cyc.push_back(lim); q_tmo.push_back(1'b1);
    end else begin
      q_res.push_back(classify(ferr, fmerr, ee, emm, ck, fdout, ed, em));
      q_cyc.push_back(c); q_tmo.push_back(1'b0);
    end
    q_tag.push_back(tag);
    start = 1'b1; mode = m; exp_data = ed; exp_mask = em;
    chk_data = ck; exp_err = ee; exp_merr = emm;
    st_busy = 1'b1; st_ack = pre; st_run = 1'b1; st_step = 1'b1;
    st_err = 1'b0; st_merr = 1'b0; st_dout = '0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) begin
        // R10: scramble the request-time inputs once accepted
        start = 1'b0; mode = ~m; exp_data = ~ed; exp_mask = ~em;
        chk_data = ~ck; exp_err = ~ee; exp_merr = ~emm; st_ack = 1'b0;
      end
      if (done) break;
      if (k == jb) st_busy = 1'b0;
      if (k == jf) begin
        if (m == 2'd1)      st_step = 1'b0;
        else if (m == 2'd2) st_run = 1'b0;
        else                st_ack = 1'b1;
        st_err = ferr; st_merr = fmerr; st_dout = fdout;
      end
    end
    st_ack = 1'b0; st_err = 1'b0; st_merr = 1'b0;
    st_busy = 1'b1; st_run = 1'b1; st_step = 1'b1;
    if ((never || c > lim) && !skip_settle) repeat (GAP + 1) @(negedge clk);
    else @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(result == 3'd0, "R1 result", int'(result), 0);
    check(cycles == '0, "R1 cycles", int'(cycles), 0);
    check(timeout == 1'b0, "R1 timeout", int'(timeout), 0);
    check(reset_req == 1'b0, "R1 reset_req", int'(reset_req), 0);

    run_cmd(2'd0, 0, 1, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R2 ack at first sample");
    run_cmd(2'd0, 0, 3, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R2 busy held high");
    run_cmd(2'd3, 0, 2, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R2 reserved mode");
    run_cmd(2'd0, 0, 2, 0, 16'h1234, 16'h00F0, 1, 0, 0, 0, 0, 16'h12C4, "R8 masked pass");
    run_cmd(2'd0, 0, 2, 0, 16'h1234, 16'h00F0, 1, 0, 0, 0, 0, 16'h1235, "R8 unmasked fail");
    run_cmd(2'd0, 0, 2, 0, 16'h1234, 16'h0000, 0, 0, 0, 0, 0, 16'hFFFF, "R8 no compare");
    run_cmd(2'd0, 0, 2, 0, 16'h1234, 16'h0000, 1, 0, 0, 1, 0, 16'h0000, "R9 err unexpected");
    run_cmd(2'd0, 0, 2, 0, 16'h0, 16'h0, 0, 1, 0, 1, 0, 16'h0, "R9 err seen");
    run_cmd(2'd0, 0, 2, 0, 16'h0, 16'h0, 0, 1, 0, 0, 0, 16'h0, "R9 err missed");
    run_cmd(2'd0, 0, 2, 0, 16'h0, 16'h0, 0, 0, 0, 0, 1, 16'h0, "R9 merr unexpected");
    run_cmd(2'd0, 0, 2, 0, 16'h0, 16'h0, 0, 0, 1, 0, 0, 16'h0, "R9 merr missed");
    run_cmd(2'd0, 0, 2, 0, 16'h0, 16'h0, 0, 0, 1, 0, 1, 16'h0, "R9 merr seen");
    run_cmd(2'd0, 0, 2, 0, 16'h0, 16'h0, 0, 0, 0, 1, 1, 16'h0, "R9 err over merr");
    run_cmd(2'd0, 0, 2, 0, 16'h0, 16'h0, 0, 1, 0, 0, 1, 16'h0, "R9 missed err over merr");
    run_cmd(2'd0, 0, 3, 0, 16'hA5A5, 16'h0000, 1, 0, 1, 0, 1, 16'hA5A5, "R10 latched expectations");
    run_cmd(2'd1, 2, 5, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R3 step flag last");
    run_cmd(2'd1, 4, 1, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R3 busy last");
    run_cmd(2'd2, 3, 1, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R4 busy last");
    run_cmd(2'd2, 0, 2, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R4 run flag alone");
    run_cmd(2'd1, 0, 0, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R6 step timeout");
    run_cmd(2'd0, 0, 5, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R6 completes on limit");
    run_cmd(2'd0, 0, 0, 1, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R5 request edge status");

    // timeout one cycle past the limit, then the reset gap
    skip_settle = 1'b1;
    run_cmd(2'd0, 0, 6, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R6 one past limit");
    skip_settle = 1'b0;
    // now one negedge after the timeout negedge (index 1)
    check(reset_req == 1'b0, "R7 reset_req dropped", int'(reset_req), 0);
    repeat (6) @(negedge clk);
    // index 7 -> sampled on edge T+8; index 8 -> edge T+9 (last blocked)
    @(negedge clk);
    start = 1'b1; mode = 2'd0; st_ack = 1'b1;
    @(negedge clk);
    st_ack = 1'b0;
    run_cmd(2'd0, 0, 2, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 16'h0, "R7 accepted after gap");

    repeat (4) @(negedge clk);
    check(q_res.size() == 0, "R11 pending results", q_res.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // reset request pulse seen on the done cycle of every timeout
  always @(negedge clk) begin
    if (!rst && done && timeout)
      check(reset_req == 1'b1, "R7 reset_req with timeout", int'(reset_req), 1);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule